// File: doc/BRIEF.md
# Slave DMA byte-count transfer controller

This block is the counter-mode engine of a slave DMA path in a device-side USB controller. A host processor loads a transfer length through four byte-wide register writes, then writes a command byte that starts either a DMA read or a DMA write. After that, the processor's active-low read and write strobes act as data beats. Each beat of the selected kind takes one off the remaining count. When the count reaches zero, the transfer is complete: a sticky done flag and an interrupt are raised.

The same two strobes also serve ordinary register access. A router sends a strobe to the register file when the transfer is idle or when `reg_sel` is high. It sends the strobe to the DMA engine when a transfer is running and `reg_sel` is low.

A running transfer can also end early, in three ways:
- a short-packet indication from the endpoint logic;
- a stop command;
- a DMA reset command.

When a write transfer (data headed to the host on IN tokens) completes by count, the block flags that a zero-length packet is owed on the next IN token. A configuration bit suppresses this flag.

Top module: `sdma_ctrl`

## Requirements
- R1: After reset, `busy`, `irq` and `zlp_pending` are low, and the counter bytes, the configuration byte (0x38) and the status byte (0x3C) all read 0.
- R2: The count is written as bytes at offsets 0x34 (bits 7:0), 0x35, 0x36 and 0x37 (bits 31:24). Writes to 0x34 to 0x36 leave the active count, as read back at those offsets, unchanged. A write to 0x37 loads all four bytes into the active count at once.
- R3: A write of 0x00 to the command byte (0x30) starts a DMA read, which counts `rd_n` beats. A write of 0x01 starts a DMA write, which counts `wr_n` beats. `busy` and status bit 2 are high from the cycle after the command.
- R4: While busy, a falling edge of the selected strobe with `reg_sel` low decrements the count by exactly one. A strobe of the other kind has no effect on the count, and so does any strobe with `reg_sel` high.
- R5: When the count reaches zero, `busy` falls and status bit 0 and `irq` rise. Both stay high until a 1 is written to bit 0 of 0x3C.
- R6: The following writes are ignored:
  - a start opcode written while busy (the direction and the count are unchanged);
  - a start opcode written while the count is 0 and counting is enabled;
  - counter byte writes made while busy.
- R7: When configuration bit 0 is 1, beats do not decrement the count and no completion by count occurs.
- R8: Command 0x0F ends a running transfer. It sets no status bit, and the count keeps its remaining value.
- R9: Command 0xFF ends any transfer, clears the count to 0 and clears `zlp_pending`, without setting status bit 0.
- R10: A `short_pkt` pulse while busy ends the transfer and sets status bit 1. It does not set bit 0, and the count keeps its value. Writing a 1 to bit 1 of 0x3C clears status bit 1.
- R11: A write transfer that completes by count sets `zlp_pending` (status bit 3) when configuration bit 1 is 0, and an `in_token` pulse clears it. When configuration bit 1 is 1, `zlp_pending` stays low. A read transfer never sets it.
- R12: Two same-cycle priorities apply:
  - when `short_pkt` arrives in the cycle of the final beat, the short packet wins: the count stays at 1 and status bit 0 is not set;
  - when `in_token` arrives in the cycle that sets `zlp_pending`, `zlp_pending` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe, shared by register reads and DMA read beats |
| wr_n | input | 1 | Active-low write strobe, shared by register writes and DMA write beats |
| reg_sel | input | 1 | High: the strobe is a register access even while busy |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| short_pkt | input | 1 | One-cycle pulse: short packet received, ends the transfer |
| in_token | input | 1 | One-cycle pulse: IN token seen, consumes the owed empty packet |
| busy | output | 1 | Transfer running |
| irq | output | 1 | Transfer-complete interrupt (sticky) |
| zlp_pending | output | 1 | Zero-length packet owed on the next IN token |

## Verification
Two events can land in the same clock cycle. The first pair is the final counting beat and a short-packet pulse: the bench drives `rd_n` low and `short_pkt` high on the same edge when one beat remains. It then expects the short-packet status, no done flag, and a count still at 1. The second pair is the final beat of a write transfer and an IN token: the bench makes them coincide and expects the owed empty packet to survive. Random transfers with random length, direction, empty-packet setting and interleaved wrong-kind strobes are compared with counts, flags and pending bits computed by bench functions.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_CMD  = 8'h30;
  localparam logic [7:0] OFS_CNT0 = 8'h34;
  localparam logic [7:0] OFS_CFG  = 8'h38;
  localparam logic [7:0] OFS_STAT = 8'h3C;

  // Command opcodes
  localparam logic [7:0] OP_READ  = 8'h00;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_STOP  = 8'h0F;
  localparam logic [7:0] OP_RESET = 8'hFF;

  typedef struct packed {
    logic start_rd;
    logic start_wr;
    logic stop;
    logic dreset;
  } cmd_t;

endpackage

// File: rtl/sdma_strobe_route.sv
module sdma_strobe_route (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic reg_sel,
  input  logic busy,
  input  logic dir_wr,
  output logic reg_wr,
  output logic beat
);

  logic rd_q, wr_q;
  logic rd_fall, wr_fall;
  logic to_regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  always_comb begin
    rd_fall = rd_q & ~rd_n;
    wr_fall = wr_q & ~wr_n;
    to_regs = reg_sel | ~busy;
    reg_wr  = wr_fall & to_regs;
    beat    = ~to_regs & (dir_wr ? wr_fall : rd_fall);
  end

endmodule

// File: rtl/sdma_regfile.sv
module sdma_regfile
  import sdma_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  load_val,
  output cmd_t              cmd,
  output logic              cfg_cnt_dis,
  output logic              cfg_no_zlp,
  output logic              w1c_ok,
  output logic              w1c_eot
);

  localparam int NB = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(OFS_CNT0) + ADDR_W'(NB - 1);

  logic [7:0] shadow_q [NB-1];
  logic       cnt_wr_ok;
  logic       is_cmd, is_cfg, is_stat;
  logic       cfg_en;
  logic [1:0] cfg_q, cfg_d;

  assign cnt_wr_ok = reg_wr & ~busy;

  // Shadow bytes for the lower part of the counter
  for (genvar i = 0; i < NB - 1; i++) begin : g_shadow
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(OFS_CNT0) + ADDR_W'(i);
    logic en;
    assign en = cnt_wr_ok & (addr == A_BYTE);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  shadow_q[i] <= '0;
      else if (en) shadow_q[i] <= wdata;
    end
  end

  always_comb begin
    cnt_load = cnt_wr_ok & (addr == A_TOP);
    load_val = '0;
    for (int i = 0; i < NB - 1; i++) load_val[8*i +: 8] = shadow_q[i];
    load_val[CNT_W-1 -: 8] = wdata;
  end

  always_comb begin
    is_cmd       = reg_wr & (addr == A_CMD);
    is_cfg       = reg_wr & (addr == A_CFG);
    is_stat      = reg_wr & (addr == A_STAT);
    cmd.start_rd = is_cmd & (wdata == OP_READ);
    cmd.start_wr = is_cmd & (wdata == OP_WRITE);
    cmd.stop     = is_cmd & (wdata == OP_STOP);
    cmd.dreset   = is_cmd & (wdata == OP_RESET);
    w1c_ok       = is_stat & wdata[0];
    w1c_eot      = is_stat & wdata[1];
    cfg_en       = is_cfg;
    cfg_d        = wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_cnt_dis = cfg_q[0];
  assign cfg_no_zlp  = cfg_q[1];

endmodule

// File: rtl/sdma_core.sv
module sdma_core
  import sdma_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd,
  input  logic             beat,
  input  logic             short_pkt,
  input  logic             in_token,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cfg_cnt_dis,
  input  logic             cfg_no_zlp,
  input  logic             w1c_ok,
  input  logic             w1c_eot,
  output logic             busy,
  output logic             dir_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             ok,
  output logic             eot,
  output logic             zlp
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d, dir_q, dir_d;
  logic ok_q, ok_d, eot_q, eot_d, zlp_q, zlp_d;
  logic ok_set, eot_set, zlp_set, zlp_kill;
  logic count_en, start;

  always_comb begin
    count_en = ~cfg_cnt_dis;
    start    = (cmd.start_rd | cmd.start_wr) & ~busy_q
             & ~(count_en & (cnt_q == '0));
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    dir_d    = dir_q;
    ok_set   = 1'b0;
    eot_set  = 1'b0;
    zlp_set  = 1'b0;
    zlp_kill = 1'b0;
    if (cmd.dreset) begin
      busy_d   = 1'b0;
      cnt_d    = '0;
      zlp_kill = 1'b1;
    end else if (cmd.stop) begin
      busy_d = 1'b0;
    end else if (busy_q && short_pkt) begin
      busy_d  = 1'b0;
      eot_set = 1'b1;
    end else if (beat && count_en) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) begin
        busy_d  = 1'b0;
        ok_set  = 1'b1;
        zlp_set = dir_q & ~cfg_no_zlp;
      end
    end else if (start) begin
      busy_d = 1'b1;
      dir_d  = cmd.start_wr;
    end else if (cnt_load) begin
      cnt_d = load_val;
    end
    ok_d  = ok_set | (ok_q & ~w1c_ok);
    eot_d = eot_set | (eot_q & ~w1c_eot);
    zlp_d = ~zlp_kill & (zlp_set | (zlp_q & ~in_token));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      ok_q   <= 1'b0;
      eot_q  <= 1'b0;
      zlp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      dir_q  <= dir_d;
      ok_q   <= ok_d;
      eot_q  <= eot_d;
      zlp_q  <= zlp_d;
    end
  end

  assign busy   = busy_q;
  assign dir_wr = dir_q;
  assign cnt    = cnt_q;
  assign ok     = ok_q;
  assign eot    = eot_q;
  assign zlp    = zlp_q;

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              short_pkt,
  input  logic              in_token,
  output logic              busy,
  output logic              irq,
  output logic              zlp_pending
);

  localparam int NB = CNT_W / 8;

  logic             reg_wr, beat, cnt_load;
  logic [CNT_W-1:0] load_val, cnt;
  cmd_t             cmd;
  logic             cfg_cnt_dis, cfg_no_zlp, w1c_ok, w1c_eot;
  logic             dir_wr, ok, eot, zlp;

  sdma_strobe_route u_route (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .reg_sel(reg_sel),
    .busy(busy), .dir_wr(dir_wr), .reg_wr(reg_wr), .beat(beat)
  );

  sdma_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .addr(addr), .wdata(wdata),
    .busy(busy), .cnt_load(cnt_load), .load_val(load_val), .cmd(cmd),
    .cfg_cnt_dis(cfg_cnt_dis), .cfg_no_zlp(cfg_no_zlp),
    .w1c_ok(w1c_ok), .w1c_eot(w1c_eot)
  );

  sdma_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .beat(beat), .short_pkt(short_pkt),
    .in_token(in_token), .cnt_load(cnt_load), .load_val(load_val),
    .cfg_cnt_dis(cfg_cnt_dis), .cfg_no_zlp(cfg_no_zlp), .w1c_ok(w1c_ok),
    .w1c_eot(w1c_eot), .busy(busy), .dir_wr(dir_wr), .cnt(cnt), .ok(ok),
    .eot(eot), .zlp(zlp)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(OFS_CNT0) + ADDR_W'(i)) rdata = cnt[8*i +: 8];
    end
    if (addr == ADDR_W'(OFS_CFG))  rdata = {6'b0, cfg_no_zlp, cfg_cnt_dis};
    if (addr == ADDR_W'(OFS_STAT)) rdata = {4'b0, zlp, busy, eot, ok};
  end

  assign irq         = ok;
  assign zlp_pending = zlp;

endmodule

// File: rtl/sdma_ctrl_chk.sv
module sdma_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq,
  input logic             zlp_pending,
  input logic             dir_wr,
  input logic             cfg_cnt_dis,
  input logic             cfg_no_zlp,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R5: the done interrupt only follows a running transfer
  assert_irq_after_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));

  // R4: a running count moves by at most one per cycle, downward
  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (cnt == $past(cnt) || cnt == $past(cnt) - ONE));

  // R7: counting disabled keeps the count frozen while running
  assert_frozen_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && $past(cfg_cnt_dis)) |-> $stable(cnt));

  // R8: an early end with count left never raises the interrupt
  assert_no_done_on_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cnt != '0) |-> !$rose(irq));

  // R11: an owed empty packet only follows an unsuppressed write transfer
  assert_zlp_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zlp_pending) |-> ($past(busy) && $past(dir_wr) && !$past(cfg_no_zlp)));

  // R6: a transfer never starts with nothing to count
  assert_start_needs_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cfg_cnt_dis) || $past(cnt) != '0));

endmodule

bind sdma_ctrl sdma_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .zlp_pending(zlp_pending),
  .dir_wr(dir_wr), .cfg_cnt_dis(cfg_cnt_dis), .cfg_no_zlp(cfg_no_zlp), .cnt(cnt)
);

// File: tb/tb_sdma_ctrl.sv
module tb_sdma_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1, reg_sel = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       short_pkt = 1'b0, in_token = 1'b0;
  logic       busy, irq, zlp_pending;
  int         checks = 0, fails = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  sdma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .reg_sel(reg_sel),
    .addr(addr), .wdata(wdata), .rdata(rdata), .short_pkt(short_pkt),
    .in_token(in_token), .busy(busy), .irq(irq), .zlp_pending(zlp_pending)
  );

  function automatic logic exp_zlp(input logic is_wr, input logic no_zlp);
    return is_wr & ~no_zlp;
  endfunction

  function automatic logic [7:0] exp_stat(input logic ok, eot, bsy, zlp);
    return {4'b0, zlp, bsy, eot, ok};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; addr = 8'h00;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 8'h00;
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd_reg(8'h34 + 8'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic load_cnt(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr_reg(8'h34 + 8'(i), v[8*i +: 8]);
  endtask

  // One strobe pulse; sel=0 is a DMA beat while busy
  task automatic strobe(input logic is_wr, input logic sel, input logic sp, input logic tok);
    @(negedge clk);
    reg_sel = sel; addr = 8'h00;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    short_pkt = sp; in_token = tok;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; reg_sel = 1'b1; short_pkt = 1'b0; in_token = 1'b0;
  endtask

  task automatic pulse_tok();
    @(negedge clk); in_token = 1'b1;
    @(negedge clk); in_token = 1'b0;
  endtask

  task automatic pulse_short();
    @(negedge clk); short_pkt = 1'b1;
    @(negedge clk); short_pkt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    logic [7:0]  r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 zlp", zlp_pending, 0);
    rd_cnt(c); chk("R1 count", c, 0);
    rd_reg(8'h38, r); chk("R1 cfg", r, 0);
    rd_reg(8'h3C, r); chk("R1 status", r, 0);

    // R2 staged byte load
    wr_reg(8'h34, 8'h11); wr_reg(8'h35, 8'h22); wr_reg(8'h36, 8'h33);
    rd_cnt(c); chk("R2 lower bytes staged", c, 0);
    wr_reg(8'h37, 8'h44);
    rd_cnt(c); chk("R2 top byte loads", c, 32'h44332211);

    // R3 start read transfer
    load_cnt(32'd3);
    wr_reg(8'h30, 8'h00);
    chk("R3 busy", busy, 1);
    rd_reg(8'h3C, r); chk("R3 status busy", r, exp_stat(0, 0, 1, 0));

    // R4 routing
    strobe(1, 0, 0, 0); rd_cnt(c); chk("R4 wrong strobe", c, 3);
    strobe(0, 1, 0, 0); rd_cnt(c); chk("R4 reg_sel strobe", c, 3);
    strobe(0, 0, 0, 0); rd_cnt(c); chk("R4 beat", c, 2);

    // R6 ignored while busy
    wr_reg(8'h30, 8'h01);
    strobe(1, 0, 0, 0); rd_cnt(c); chk("R6 direction kept", c, 2);
    wr_reg(8'h37, 8'h09); rd_cnt(c); chk("R6 load while busy", c, 2);

    // R5 completion
    strobe(0, 0, 0, 0); strobe(0, 0, 0, 0);
    chk("R5 busy low", busy, 0);
    chk("R5 irq", irq, 1);
    chk("R11 read sets no zlp", zlp_pending, 0);
    repeat (3) @(negedge clk);
    chk("R5 sticky", irq, 1);
    wr_reg(8'h3C, 8'h01);
    chk("R5 cleared", irq, 0);

    // R6 zero count start ignored
    wr_reg(8'h30, 8'h00);
    chk("R6 zero count", busy, 0);

    // R11 empty packet owed after write
    load_cnt(32'd2); wr_reg(8'h30, 8'h01);
    strobe(1, 0, 0, 0); strobe(1, 0, 0, 0);
    chk("R11 zlp set", zlp_pending, 1);
    rd_reg(8'h3C, r); chk("R11 status", r, exp_stat(1, 0, 0, 1));
    pulse_tok();
    chk("R11 zlp consumed", zlp_pending, 0);
    wr_reg(8'h3C, 8'h01);
    wr_reg(8'h38, 8'h02);
    load_cnt(32'd1); wr_reg(8'h30, 8'h01); strobe(1, 0, 0, 0);
    chk("R11 suppressed", zlp_pending, 0);
    chk("R11 suppressed done", irq, 1);
    wr_reg(8'h3C, 8'h01); wr_reg(8'h38, 8'h00);

    // R7 counting disabled
    wr_reg(8'h38, 8'h01);
    load_cnt(32'd2); wr_reg(8'h30, 8'h00);
    strobe(0, 0, 0, 0); strobe(0, 0, 0, 0); strobe(0, 0, 0, 0);
    rd_cnt(c); chk("R7 count frozen", c, 2);
    chk("R7 still busy", busy, 1);
    wr_reg(8'h30, 8'h0F);
    wr_reg(8'h38, 8'h00);

    // R8 stop
    load_cnt(32'd5); wr_reg(8'h30, 8'h00);
    strobe(0, 0, 0, 0);
    wr_reg(8'h30, 8'h0F);
    chk("R8 busy", busy, 0);
    chk("R8 irq", irq, 0);
    rd_cnt(c); chk("R8 remaining", c, 4);

    // R10 short packet
    wr_reg(8'h30, 8'h00);
    strobe(0, 0, 0, 0);
    pulse_short();
    chk("R10 busy", busy, 0);
    rd_reg(8'h3C, r); chk("R10 status", r, exp_stat(0, 1, 0, 0));
    rd_cnt(c); chk("R10 remaining", c, 3);
    wr_reg(8'h3C, 8'h02);
    rd_reg(8'h3C, r); chk("R10 cleared", r, 0);

    // R9 DMA reset
    load_cnt(32'd2); wr_reg(8'h30, 8'h01);
    strobe(1, 0, 0, 0); strobe(1, 0, 0, 0);
    wr_reg(8'h3C, 8'h01);
    load_cnt(32'd3); wr_reg(8'h30, 8'h00);
    wr_reg(8'h30, 8'hFF);
    chk("R9 busy", busy, 0);
    rd_cnt(c); chk("R9 count", c, 0);
    chk("R9 zlp", zlp_pending, 0);
    chk("R9 irq", irq, 0);

    // R12 same-cycle: final beat and short packet
    load_cnt(32'd1); wr_reg(8'h30, 8'h00);
    strobe(0, 0, 1, 0);
    chk("R12 busy", busy, 0);
    rd_reg(8'h3C, r); chk("R12 short wins", r, exp_stat(0, 1, 0, 0));
    rd_cnt(c); chk("R12 count kept", c, 1);
    wr_reg(8'h3C, 8'h02);

    // R12 same-cycle: final write beat and IN token
    wr_reg(8'h30, 8'h01);
    strobe(1, 0, 0, 1);
    chk("R12 zlp survives", zlp_pending, 1);
    chk("R12 done", irq, 1);
    wr_reg(8'h3C, 8'h01); pulse_tok();

    // Random transfers (R4, R5, R11)
    for (int it = 0; it < 40; it++) begin
      int   n;
      logic d, ne;
      n  = $urandom_range(1, 10);
      d  = 1'($urandom_range(0, 1));
      ne = 1'($urandom_range(0, 1));
      wr_reg(8'h38, {6'b0, ne, 1'b0});
      load_cnt(32'(n));
      wr_reg(8'h30, {7'b0, d});
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 2) == 0) strobe(~d, 0, 0, 0);
        if ($urandom_range(0, 3) == 0) strobe(d, 1, 0, 0);
        strobe(d, 0, 0, 0);
      end
      chk("R5 random busy", busy, 0);
      chk("R5 random irq", irq, 1);
      chk("R11 random zlp", zlp_pending, exp_zlp(d, ne));
      rd_cnt(c); chk("R4 random count", c, 0);
      wr_reg(8'h3C, 8'h01);
      pulse_tok();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule